// File: doc/BRIEF.md
# Posted Write Buffer with Read Bypass

This block sits between a burst sequencer and a storage array whose locations are two external words wide. A write command does not reach the array when it is issued. Its location address, its two-word data and a per-word enable mask are parked in a staging register. The parked write goes into the array only when the next write command arrives, in the same cycle that the new write takes its place in the staging register. Any number of reads can run while a write is parked, and the parked entry stays untouched through all of them.

Every read starts an array access. When a write is parked, the read address is also compared with the parked address over the full location address width. On a match, each word that the parked write enabled is taken from the staging register and the other word comes from the array. A read in the cycle right after a write to the same location therefore sees the new data even though the array has not been written. Read data appears one cycle after the read command. An output flag marks which words were forwarded.

Top module: `posted_write_buf`

## Requirements
- R1: After reset nothing is parked. The first write after reset drives no array write, and no read forwards data (`rd_hit_o` = 00) until a new write is parked.
- R2: Read commands never write the array (`arr_we_o` stays 0 on read cycles). A parked write survives any number of reads unchanged.
- R3: A write command while a write is parked drives `arr_we_o`=1 in that same cycle, with `arr_waddr_o`, `arr_wdata_o` and `arr_wmask_o` equal to the parked write's address, data and enable mask. The new write then becomes the parked entry.
- R4: A read command drives `arr_re_o`=1 and `arr_raddr_o` equal to the command address in the same cycle. `rd_valid_o` is 1 exactly in the cycle after a read command.
- R5: A read whose address equals the parked address returns the parked data for the parked write's enabled words. `rd_hit_o` equals that enable mask.
- R6: A read issued in the cycle directly after a write to the same address returns the data of that write.
- R7: Word 0 occupies bits [BEAT_W-1:0] and word 1 the bits above them, and enable bit i belongs to word i. On a hit, words whose enable bit is 0 are read from the array.
- R8: A read to any address other than the parked one returns array data with `rd_hit_o` = 00.
- R9: Data written to the array by a commit is returned from the array by later reads of that address.
- R10: A commit writes only the enabled words (`arr_wmask_o`). The array word with a 0 mask bit keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Array location address |
| cmd_wdata_i | input | 2*BEAT_W | Write data, word 1 above word 0 |
| cmd_ben_i | input | 2 | Per-word write enable |
| arr_we_o | output | 1 | Array write strobe (commit) |
| arr_waddr_o | output | ADDR_W | Commit address |
| arr_wdata_o | output | 2*BEAT_W | Commit data |
| arr_wmask_o | output | 2 | Commit word mask |
| arr_re_o | output | 1 | Array read strobe |
| arr_raddr_o | output | ADDR_W | Array read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 2*BEAT_W | Read data |
| rd_hit_o | output | 2 | Words forwarded from the staging register |

## Verification
Two things can meet in one read: words forwarded from the staging register and words fetched from the array. The bench provokes this by parking a write with only one word enabled over a location that already holds different array data, then reading that location. The result must combine the parked word with the array's other word, and `rd_hit_o` must name the forwarded word. The same is done with the other word, right after a commit has refreshed the array location, so that a commit and a forward touch the same address in consecutive cycles.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned BEATS = 2;
  typedef logic [BEATS-1:0] beat_mask_t;
endpackage

// File: rtl/pwb_stage.sv
module pwb_stage
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  beat_mask_t        ben_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output beat_mask_t        st_mask_o,
  output logic              commit_o,
  output beat_mask_t        hit_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] st_addr_q;
  logic [DATA_W-1:0] st_data_q;
  beat_mask_t        st_mask_q;
  logic              addr_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      st_addr_q <= '0;
      st_data_q <= '0;
      st_mask_q <= '0;
    end else if (wr_i) begin
      pend_q    <= 1'b1;
      st_addr_q <= addr_i;
      st_data_q <= wdata_i;
      st_mask_q <= ben_i;
    end
  end

  // compare is only meaningful for a read against a parked entry
  assign addr_eq  = (addr_i == st_addr_q);
  assign hit_o    = (rd_i && pend_q && addr_eq) ? st_mask_q : '0;
  assign commit_o = wr_i && pend_q;

  assign pend_o    = pend_q;
  assign st_addr_o = st_addr_q;
  assign st_data_o = st_data_q;
  assign st_mask_o = st_mask_q;

  a_r3_stage_capture : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (pend_q && st_addr_q == $past(addr_i) && st_data_q == $past(wdata_i)
              && st_mask_q == $past(ben_i)));

  a_r2_hold_on_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> ($stable(pend_q) && $stable(st_addr_q) && $stable(st_data_q)
                         && $stable(st_mask_q)));
endmodule

// File: rtl/pwb_array.sv
module pwb_array
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BEAT_W = 36
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [BEATS*BEAT_W-1:0] wdata_i,
  input  beat_mask_t              wmask_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [BEATS*BEAT_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic [BEAT_W-1:0] mem [DEPTH];
    logic [BEAT_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[b]) mem[waddr_i] <= wdata_i[b*BEAT_W +: BEAT_W];
      if (re_i) rd_q <= mem[raddr_i];
    end

    assign rdata_o[b*BEAT_W +: BEAT_W] = rd_q;
  end
endmodule

// File: rtl/pwb_rdpath.sv
module pwb_rdpath
  import pwb_pkg::*;
#(
  parameter int unsigned BEAT_W = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  beat_mask_t              hit_i,
  input  logic [BEATS*BEAT_W-1:0] st_data_i,
  input  logic [BEATS*BEAT_W-1:0] arr_rdata_i,
  output logic                    rvalid_o,
  output beat_mask_t              rhit_o,
  output logic [BEATS*BEAT_W-1:0] rdata_o
);
  logic                    rvalid_q;
  beat_mask_t              hit_q;
  logic [BEATS*BEAT_W-1:0] fwd_q;

  // staged data is sampled with the read so a following commit cannot disturb it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      hit_q    <= '0;
      fwd_q    <= '0;
    end else begin
      rvalid_q <= rd_i;
      hit_q    <= rd_i ? hit_i : '0;
      if (rd_i) fwd_q <= st_data_i;
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_mux
    assign rdata_o[b*BEAT_W +: BEAT_W] = hit_q[b] ? fwd_q[b*BEAT_W +: BEAT_W]
                                                  : arr_rdata_i[b*BEAT_W +: BEAT_W];
  end

  assign rvalid_o = rvalid_q;
  assign rhit_o   = hit_q;

  a_r4_valid_after_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_q);
endmodule

// File: rtl/posted_write_buf.sv
module posted_write_buf
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BEAT_W = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic                    cmd_write_i,
  input  logic [ADDR_W-1:0]       cmd_addr_i,
  input  logic [2*BEAT_W-1:0]     cmd_wdata_i,
  input  logic [1:0]              cmd_ben_i,
  output logic                    arr_we_o,
  output logic [ADDR_W-1:0]       arr_waddr_o,
  output logic [2*BEAT_W-1:0]     arr_wdata_o,
  output logic [1:0]              arr_wmask_o,
  output logic                    arr_re_o,
  output logic [ADDR_W-1:0]       arr_raddr_o,
  output logic                    rd_valid_o,
  output logic [2*BEAT_W-1:0]     rd_data_o,
  output logic [1:0]              rd_hit_o
);
  localparam int unsigned DATA_W = BEATS * BEAT_W;

  logic              wr, rd, pend, commit;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data, arr_rdata;
  beat_mask_t        st_mask, hit;

  assign wr = cmd_valid_i && cmd_write_i;
  assign rd = cmd_valid_i && !cmd_write_i;

  pwb_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk_i, .rst_ni,
    .wr_i(wr), .rd_i(rd), .addr_i(cmd_addr_i), .wdata_i(cmd_wdata_i), .ben_i(cmd_ben_i),
    .pend_o(pend), .st_addr_o(st_addr), .st_data_o(st_data), .st_mask_o(st_mask),
    .commit_o(commit), .hit_o(hit)
  );

  pwb_array #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_array (
    .clk_i,
    .we_i(commit), .waddr_i(st_addr), .wdata_i(st_data), .wmask_i(st_mask),
    .re_i(rd), .raddr_i(cmd_addr_i), .rdata_o(arr_rdata)
  );

  pwb_rdpath #(.BEAT_W(BEAT_W)) u_rdpath (
    .clk_i, .rst_ni,
    .rd_i(rd), .hit_i(hit), .st_data_i(st_data), .arr_rdata_i(arr_rdata),
    .rvalid_o(rd_valid_o), .rhit_o(rd_hit_o), .rdata_o(rd_data_o)
  );

  assign arr_we_o    = commit;
  assign arr_waddr_o = st_addr;
  assign arr_wdata_o = st_data;
  assign arr_wmask_o = st_mask;
  assign arr_re_o    = rd;
  assign arr_raddr_o = cmd_addr_i;

  a_r5_hit_needs_parked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_o != 2'b00) |-> $past(pend && rd && cmd_addr_i == st_addr));

  a_r7_hit_within_mask : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_o != 2'b00) |-> ((rd_hit_o & ~$past(st_mask)) == 2'b00));

  a_r4_valid_only_after_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i && !cmd_write_i));

  a_r2_no_write_on_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_write_i) |-> !arr_we_o);
endmodule

// File: tb/posted_write_buf_bench.sv
module posted_write_buf_bench;
  localparam int AW = 6;
  localparam int BW = 36;
  localparam int DW = 2 * BW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [1:0]    cmd_ben = '0;
  logic          arr_we, arr_re, rd_valid;
  logic [AW-1:0] arr_waddr, arr_raddr;
  logic [DW-1:0] arr_wdata, rd_data;
  logic [1:0]    arr_wmask, rd_hit;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  posted_write_buf #(.ADDR_W(AW), .BEAT_W(BW)) u_posted_write_buf (
    .clk_i(clk), .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .cmd_ben_i(cmd_ben),
    .arr_we_o(arr_we), .arr_waddr_o(arr_waddr), .arr_wdata_o(arr_wdata),
    .arr_wmask_o(arr_wmask), .arr_re_o(arr_re), .arr_raddr_o(arr_raddr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_hit_o(rd_hit)
  );

  localparam logic [DW-1:0] D1 = {36'hA_1111_1111, 36'h1_0000_0001};
  localparam logic [DW-1:0] D2 = {36'hB_2222_2222, 36'h2_0000_0002};
  localparam logic [DW-1:0] D3 = {36'hC_3333_3333, 36'h3_0000_0003};
  localparam logic [DW-1:0] D4 = {36'hD_4444_4444, 36'h4_0000_0004};
  localparam logic [DW-1:0] D5 = {36'hE_5555_5555, 36'h5_0000_0005};
  localparam logic [DW-1:0] D6 = {36'hF_6666_6666, 36'h6_0000_0006};

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d; cmd_ben = e;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
    #1;
  endtask

  // read, then check result one cycle later
  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                        input logic [1:0] exp_hit, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    #1;
    chk(arr_re === 1'b1 && arr_raddr === a, "R4 read strobe", {arr_re, arr_raddr},
        {1'b1, a});
    chk(arr_we === 1'b0, "R2 no array write on read", DW'(arr_we), '0);
    idle();
    chk(rd_valid === 1'b1, "R4 read valid", DW'(rd_valid), DW'(1));
    chk(rd_data === exp_d, req, rd_data, exp_d);
    chk(rd_hit === exp_hit, {req, " hit"}, DW'(rd_hit), DW'(exp_hit));
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_valid = 1'b0; rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    idle();
    chk(rd_valid === 1'b0 && rd_hit === 2'b00, "R1 reset outputs",
        DW'({rd_valid, rd_hit}), '0);
    chk(arr_we === 1'b0 && arr_re === 1'b0, "R4 idle strobes", DW'({arr_we, arr_re}), '0);
  endtask

  task automatic t_first_write();
    wr(5, D1, 2'b11);
    chk(arr_we === 1'b0, "R1 first write not committed", DW'(arr_we), '0);
    rd_chk(5, D1, 2'b11, "R6 read right after write");
  endtask

  task automatic t_commit();
    wr(9, D2, 2'b11);
    chk(arr_we === 1'b1, "R3 commit strobe", DW'(arr_we), DW'(1));
    chk(arr_waddr === 6'd5 && arr_wmask === 2'b11, "R3 commit addr/mask",
        DW'({arr_waddr, arr_wmask}), DW'({6'd5, 2'b11}));
    chk(arr_wdata === D1, "R3 commit data", arr_wdata, D1);
    rd_chk(5, D1, 2'b00, "R9 committed data from array");
    rd_chk(9, D2, 2'b11, "R5 parked hit");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) rd_chk(5, D1, 2'b00, "R2 array read while parked");
    rd_chk(9, D2, 2'b11, "R2 parked entry survives reads");
  endtask

  task automatic t_partial();
    wr(5, D3, 2'b01);
    chk(arr_we === 1'b1 && arr_waddr === 6'd9 && arr_wdata === D2, "R3 commit 9",
        arr_wdata, D2);
    rd_chk(5, {D1[DW-1:BW], D3[BW-1:0]}, 2'b01, "R7 mixed forward and array");
  endtask

  task automatic t_masked_commit();
    wr(12, D4, 2'b11);
    chk(arr_we === 1'b1 && arr_waddr === 6'd5 && arr_wmask === 2'b01,
        "R10 commit mask", DW'({arr_we, arr_waddr, arr_wmask}), DW'({1'b1, 6'd5, 2'b01}));
    rd_chk(5, {D1[DW-1:BW], D3[BW-1:0]}, 2'b00, "R10 unmasked word kept");
  endtask

  task automatic t_miss();
    rd_chk(9, D2, 2'b00, "R8 miss reads array");
  endtask

  task automatic t_upper_only();
    wr(12, D5, 2'b10);
    chk(arr_we === 1'b1 && arr_waddr === 6'd12 && arr_wdata === D4, "R3 commit 12",
        arr_wdata, D4);
    rd_chk(12, {D5[DW-1:BW], D4[BW-1:0]}, 2'b10, "R7 upper word forwarded");
  endtask

  task automatic t_reset_drops();
    do_reset();
    rd_chk(12, D4, 2'b00, "R1 no hit after reset");
    wr(20, D6, 2'b11);
    chk(arr_we === 1'b0, "R1 first write after reset", DW'(arr_we), '0);
    rd_chk(12, D4, 2'b00, "R1 dropped entry never committed");
  endtask

  initial begin
    t_reset();
    t_first_write();
    t_commit();
    t_hold();
    t_partial();
    t_masked_commit();
    t_miss();
    t_upper_only();
    t_reset_drops();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule